// File: doc/BRIEF.md
# Sync Flood Detector and Generator

This block watches the receive side of a point-to-point link for the resynchronization condition and drives the same condition on the transmit side. On receive it looks at the lowest eight lanes of the command/address lane group once per bit time. It raises a sticky sync indication in two cases. The first is a run of all-ones bit times long enough for the configured link width. The second is a complete four-byte information packet made only of ones, which carries the command code 111111. Run-length detection needs no trust in the decoded clock rate or link width. The threshold still grows as the link narrows, because each bit time then carries fewer bits.

On transmit, an error or reset request puts the block into flood mode. In flood mode every transmit lane is forced to one, whatever data and flow-control state the normal path holds. The flood stays on until the link-reset input clears it, and the same input clears the receive indication.

The block has two FSMs on the receive side: a run-length FSM (`RUN_IDLE`, `RUN_COUNT`, `RUN_HIT`) and a packet FSM (`PD_IDLE`, `PD_BODY`, `PD_DONE`). Both feed a receive FSM (`RX_HUNT` → `RX_SYNCED`). On the transmit side a flood FSM (`TX_PASS` → `TX_FLOOD`) drives the lanes.

The run-length FSM moves as follows:
- `RUN_IDLE` goes to `RUN_COUNT` on the first all-ones beat.
- `RUN_COUNT` goes back to `RUN_IDLE` on any beat containing a zero.
- `RUN_COUNT` goes to `RUN_HIT` when the run reaches the threshold.

The packet FSM moves as follows:
- `PD_IDLE` goes to `PD_BODY` on an all-ones beat that is marked as a packet start.
- `PD_BODY` goes back to `PD_IDLE` on any zero.
- `PD_BODY` goes to `PD_DONE` once 32 bits of ones have been seen.
- `PD_DONE` returns to `PD_IDLE` after one cycle.

The link-reset input returns every FSM to its first state.

Top module: `sync_flood_unit`

## Requirements
- R1: After `rst_n` is released, `sync_detected` and `flood_active` are 0, and `tx_lanes_out` equals `tx_data_in`.
- R2: With `width_cfg` 2'b10 or 2'b11 (8 lanes or wider), 16 consecutive valid bit times with `rx_lanes[7:0]` all ones set `sync_detected` one cycle after the clock edge that takes the 16th beat. 15 such beats do not set it.
- R3: With `width_cfg` 2'b01 (4 lanes), the threshold is 32 valid beats with `rx_lanes[3:0]` all ones, and `rx_lanes[7:4]` are ignored. 31 beats do not set `sync_detected`.
- R4: With `width_cfg` 2'b00 (2 lanes), the threshold is 64 valid beats with `rx_lanes[1:0]` all ones, and `rx_lanes[7:2]` are ignored. 63 beats do not set `sync_detected`.
- R5: A valid beat with a zero on any active lane restarts the run count from zero.
- R6: Cycles with `rx_valid` low are not bit times. They neither advance nor clear the run.
- R7: A sync packet is detected when a valid beat with `rx_pkt_start` high is followed by the rest of 32 bits of ones on the active lanes: 4 beats at 8 lanes, 8 at 4 lanes, 16 at 2 lanes. Detection sets `sync_detected` with the same one-cycle latency as R2. A packet cut short does not set it.
- R8: All-ones beats without a packet start count only toward the run threshold. A packet with a zero on an active lane is abandoned.
- R9: `sync_detected` stays high until `link_reset` is sampled high, and is low in the following cycle.
- R10: `tx_err_req` sampled high sets `flood_active` in the next cycle. While `flood_active` is high, `tx_lanes_out` is all ones regardless of `tx_data_in`. The flood holds until `link_reset`.
- R11: `link_reset` takes priority: an error request or a final threshold beat in the same cycle leaves `flood_active` and `sync_detected` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_reset | input | 1 | Synchronous link reset; clears the detection and the flood |
| width_cfg | input | 2 | Link width: 00 = 2 lanes, 01 = 4 lanes, 10/11 = 8 or more |
| rx_valid | input | 1 | The receive lanes carry a bit time |
| rx_pkt_start | input | 1 | This beat is the first beat of a control packet |
| rx_lanes | input | 8 | Lowest eight receive lanes |
| tx_err_req | input | 1 | Error or reset request that starts the flood |
| tx_data_in | input | TX_W | Normal transmit data |
| tx_lanes_out | output | TX_W | Transmit lanes, all ones while flooding |
| sync_detected | output | 1 | Sticky sync event indication |
| flood_active | output | 1 | Transmit flood in progress |

## Verification
The hardest conditions to reach are the exact threshold boundaries. The worst case is 64 beats on a two-lane link, where a count one short must stay silent. The threshold beat landing in the same cycle as a link reset is equally hard to hit. A vector table drives runs of exactly the threshold and one less for each width, with the unused lanes held at zero to show they are ignored. Directed sequences then place a zero beat, a gap in `rx_valid`, or a `link_reset` on the precise beat where they matter.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
    typedef enum logic [1:0] {
        LW_2    = 2'b00,
        LW_4    = 2'b01,
        LW_8    = 2'b10,
        LW_WIDE = 2'b11
    } lane_width_e;

    typedef enum logic [1:0] {RUN_IDLE, RUN_COUNT, RUN_HIT} run_state_e;
    typedef enum logic [1:0] {PD_IDLE, PD_BODY, PD_DONE} pd_state_e;
    typedef enum logic {RX_HUNT, RX_SYNCED} rx_state_e;
    typedef enum logic {TX_PASS, TX_FLOOD} tx_state_e;
endpackage

// File: rtl/sfl_lane_qual.sv
module sfl_lane_qual #(
    parameter int OBS_W = 8
) (
    input  logic [1:0]       width_cfg,
    input  logic [OBS_W-1:0] lanes,
    output logic             all_ones
);
    import sfl_pkg::*;

    localparam int ACT_W = $clog2(OBS_W + 1);

    logic [ACT_W-1:0] act_cnt;
    logic [OBS_W-1:0] lane_ok;

    always_comb begin
        unique case (lane_width_e'(width_cfg))
            LW_2:    act_cnt = ACT_W'(2);
            LW_4:    act_cnt = ACT_W'(4);
            default: act_cnt = ACT_W'(OBS_W);
        endcase
    end

    // A lane outside the configured width always counts as one.
    for (genvar i = 0; i < OBS_W; i++) begin : g_lane
        assign lane_ok[i] = lanes[i] | (ACT_W'(i) >= act_cnt);
    end

    assign all_ones = &lane_ok;
endmodule

// File: rtl/sfl_run_detect.sv
module sfl_run_detect #(
    parameter int RUN_BASE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_reset,
    input  logic [1:0] width_cfg,
    input  logic       beat_valid,
    input  logic       beat_ones,
    output logic       run_hit
);
    import sfl_pkg::*;

    localparam int CNT_W = $clog2(RUN_BASE * 4 + 1);

    run_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] thr;

    always_comb begin
        unique case (lane_width_e'(width_cfg))
            LW_2:    thr = CNT_W'(RUN_BASE * 4);
            LW_4:    thr = CNT_W'(RUN_BASE * 2);
            default: thr = CNT_W'(RUN_BASE);
        endcase
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (link_reset) begin
            st_d  = RUN_IDLE;
            cnt_d = '0;
        end else if (beat_valid) begin
            unique case (st_q)
                RUN_IDLE: begin
                    if (beat_ones) begin
                        st_d  = RUN_COUNT;
                        cnt_d = CNT_W'(1);
                    end
                end
                RUN_COUNT: begin
                    if (!beat_ones) begin
                        st_d  = RUN_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (cnt_q + CNT_W'(1) >= thr) st_d = RUN_HIT;
                    end
                end
                RUN_HIT: st_d = RUN_HIT;
                default: st_d = RUN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RUN_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb run_hit = (st_q == RUN_HIT);
endmodule

// File: rtl/sfl_pkt_decode.sv
module sfl_pkt_decode #(
    parameter int PKT_BITS = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_reset,
    input  logic [1:0] width_cfg,
    input  logic       beat_valid,
    input  logic       beat_start,
    input  logic       beat_ones,
    output logic       pkt_hit
);
    import sfl_pkg::*;

    localparam int PC_W = $clog2(PKT_BITS / 2 + 1);

    pd_state_e       st_q, st_d;
    logic [PC_W-1:0] cnt_q, cnt_d;
    logic [PC_W-1:0] need;

    always_comb begin
        unique case (lane_width_e'(width_cfg))
            LW_2:    need = PC_W'(PKT_BITS / 2);
            LW_4:    need = PC_W'(PKT_BITS / 4);
            default: need = PC_W'(PKT_BITS / 8);
        endcase
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (link_reset) begin
            st_d  = PD_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PD_IDLE, PD_DONE: begin
                    st_d  = PD_IDLE;
                    cnt_d = '0;
                    if (beat_valid && beat_start && beat_ones) begin
                        st_d  = PD_BODY;
                        cnt_d = PC_W'(1);
                    end
                end
                PD_BODY: begin
                    if (beat_valid) begin
                        if (!beat_ones) begin
                            st_d  = PD_IDLE;
                            cnt_d = '0;
                        end else if (beat_start) begin
                            cnt_d = PC_W'(1);
                        end else if (cnt_q + PC_W'(1) == need) begin
                            st_d  = PD_DONE;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + PC_W'(1);
                        end
                    end
                end
                default: st_d = PD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PD_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb pkt_hit = (st_q == PD_DONE);
endmodule

// File: rtl/sfl_rx_state.sv
module sfl_rx_state (
    input  logic clk,
    input  logic rst_n,
    input  logic link_reset,
    input  logic run_hit,
    input  logic pkt_hit,
    output logic sync_detected
);
    import sfl_pkg::*;

    rx_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (link_reset) begin
            st_d = RX_HUNT;
        end else begin
            unique case (st_q)
                RX_HUNT:   if (run_hit || pkt_hit) st_d = RX_SYNCED;
                RX_SYNCED: st_d = RX_SYNCED;
                default:   st_d = RX_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_HUNT;
        else        st_q <= st_d;
    end

    always_comb sync_detected = (st_q == RX_SYNCED);
endmodule

// File: rtl/sfl_tx_flood.sv
module sfl_tx_flood #(
    parameter int TX_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_reset,
    input  logic            err_req,
    input  logic [TX_W-1:0] data_in,
    output logic [TX_W-1:0] lanes_out,
    output logic            flood_active
);
    import sfl_pkg::*;

    tx_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (link_reset) begin
            st_d = TX_PASS;
        end else begin
            unique case (st_q)
                TX_PASS:  if (err_req) st_d = TX_FLOOD;
                TX_FLOOD: st_d = TX_FLOOD;
                default:  st_d = TX_PASS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_PASS;
        else        st_q <= st_d;
    end

    always_comb begin
        flood_active = (st_q == TX_FLOOD);
        lanes_out    = flood_active ? {TX_W{1'b1}} : data_in;
    end
endmodule

// File: rtl/sync_flood_unit.sv
module sync_flood_unit #(
    parameter int OBS_W    = 8,
    parameter int RUN_BASE = 16,
    parameter int PKT_BITS = 32,
    parameter int TX_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_reset,
    input  logic [1:0]      width_cfg,
    input  logic            rx_valid,
    input  logic            rx_pkt_start,
    input  logic [OBS_W-1:0] rx_lanes,
    input  logic            tx_err_req,
    input  logic [TX_W-1:0] tx_data_in,
    output logic [TX_W-1:0] tx_lanes_out,
    output logic            sync_detected,
    output logic            flood_active
);
    logic beat_ones;
    logic run_hit;
    logic pkt_hit;

    sfl_lane_qual #(.OBS_W(OBS_W)) u_qual (
        .width_cfg (width_cfg),
        .lanes     (rx_lanes),
        .all_ones  (beat_ones)
    );

    sfl_run_detect #(.RUN_BASE(RUN_BASE)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_reset (link_reset),
        .width_cfg  (width_cfg),
        .beat_valid (rx_valid),
        .beat_ones  (beat_ones),
        .run_hit    (run_hit)
    );

    sfl_pkt_decode #(.PKT_BITS(PKT_BITS)) u_pkt (
        .clk        (clk),
        .rst_n      (rst_n),
        .link_reset (link_reset),
        .width_cfg  (width_cfg),
        .beat_valid (rx_valid),
        .beat_start (rx_pkt_start),
        .beat_ones  (beat_ones),
        .pkt_hit    (pkt_hit)
    );

    sfl_rx_state u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_reset    (link_reset),
        .run_hit       (run_hit),
        .pkt_hit       (pkt_hit),
        .sync_detected (sync_detected)
    );

    sfl_tx_flood #(.TX_W(TX_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_reset   (link_reset),
        .err_req      (tx_err_req),
        .data_in      (tx_data_in),
        .lanes_out    (tx_lanes_out),
        .flood_active (flood_active)
    );
endmodule

// File: rtl/sfl_checker.sv
module sfl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       link_reset,
    input logic [1:0] width_cfg,
    input logic       rx_valid,
    input logic [7:0] rx_lanes,
    input logic       tx_err_req,
    input logic       sync_detected,
    input logic       flood_active
);
    logic masked_ones;

    always_comb begin
        case (width_cfg)
            2'b00:   masked_ones = (rx_lanes[1:0] == 2'b11);
            2'b01:   masked_ones = (rx_lanes[3:0] == 4'hF);
            default: masked_ones = (rx_lanes == 8'hFF);
        endcase
    end

    AST_STICKY_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync_detected && !link_reset |=> sync_detected); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        link_reset |=> !sync_detected && !flood_active); // R11

    AST_FLOOD_START: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err_req && !link_reset |=> flood_active); // R10

    AST_FLOOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        flood_active && !link_reset |=> flood_active); // R10

    AST_RISE_AFTER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_detected) |-> $past(rx_valid, 2) && $past(masked_ones, 2)); // R5
endmodule

bind sync_flood_unit sfl_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_reset    (link_reset),
    .width_cfg     (width_cfg),
    .rx_valid      (rx_valid),
    .rx_lanes      (rx_lanes),
    .tx_err_req    (tx_err_req),
    .sync_detected (sync_detected),
    .flood_active  (flood_active)
);

// File: tb/sync_flood_unit_tb.sv
`timescale 1ns/1ps
module sync_flood_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_reset = 1'b0;
    logic [1:0] width_cfg = 2'b10;
    logic       rx_valid = 1'b0;
    logic       rx_pkt_start = 1'b0;
    logic [7:0] rx_lanes = 8'h00;
    logic       tx_err_req = 1'b0;
    logic [7:0] tx_data_in = 8'h5A;
    logic [7:0] tx_lanes_out;
    logic       sync_detected;
    logic       flood_active;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sync_flood_unit u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .link_reset    (link_reset),
        .width_cfg     (width_cfg),
        .rx_valid      (rx_valid),
        .rx_pkt_start  (rx_pkt_start),
        .rx_lanes      (rx_lanes),
        .tx_err_req    (tx_err_req),
        .tx_data_in    (tx_data_in),
        .tx_lanes_out  (tx_lanes_out),
        .sync_detected (sync_detected),
        .flood_active  (flood_active)
    );

    // {width_cfg[1:0], packet_start, expect_sync, beats[7:0]}
    localparam logic [11:0] VEC [12] = '{
        {2'b10, 1'b0, 1'b1, 8'd16},  // R2 exact threshold
        {2'b10, 1'b0, 1'b0, 8'd15},  // R2 one short
        {2'b11, 1'b0, 1'b1, 8'd16},  // R2 wide link
        {2'b01, 1'b0, 1'b1, 8'd32},  // R3 threshold, upper lanes zero
        {2'b01, 1'b0, 1'b0, 8'd31},  // R3 one short
        {2'b00, 1'b0, 1'b1, 8'd64},  // R4 threshold, upper lanes zero
        {2'b00, 1'b0, 1'b0, 8'd63},  // R4 one short
        {2'b10, 1'b1, 1'b1, 8'd4},   // R7 packet at 8 lanes
        {2'b01, 1'b1, 1'b1, 8'd8},   // R7 packet at 4 lanes
        {2'b00, 1'b1, 1'b1, 8'd16},  // R7 packet at 2 lanes
        {2'b10, 1'b1, 1'b0, 8'd3},   // R7 packet cut short
        {2'b10, 1'b0, 1'b0, 8'd4}    // R8 no packet start
    };

    function automatic logic [7:0] act_mask(input logic [1:0] c);
        case (c)
            2'b00:   return 8'h03;
            2'b01:   return 8'h0F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic beat(input logic [7:0] l, input logic v, input logic s);
        @(negedge clk);
        rx_lanes     = l;
        rx_valid     = v;
        rx_pkt_start = s;
    endtask

    task automatic lreset();
        @(negedge clk);
        link_reset   = 1'b1;
        rx_valid     = 1'b0;
        rx_pkt_start = 1'b0;
        rx_lanes     = 8'h00;
        @(negedge clk);
        link_reset = 1'b0;
    endtask

    // Drops the lanes, lets the result register, samples at the next negedge.
    task automatic settle();
        beat(8'h00, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete act=hang exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sync after reset", 32'(sync_detected), 0);
        check("R1 flood after reset", 32'(flood_active), 0);
        check("R1 tx passthrough", 32'(tx_lanes_out), 32'h5A);

        for (int i = 0; i < 12; i++) begin
            lreset();
            width_cfg = VEC[i][11:10];
            for (int k = 0; k < int'(VEC[i][7:0]); k++)
                beat(act_mask(VEC[i][11:10]), 1'b1, VEC[i][9] && (k == 0));
            settle();
            check($sformatf("R2/R3/R4/R7/R8 vector %0d", i), 32'(sync_detected), 32'(VEC[i][8]));
        end

        // R5: a zero beat restarts the run
        lreset();
        width_cfg = 2'b10;
        for (int k = 0; k < 10; k++) beat(8'hFF, 1'b1, 1'b0);
        beat(8'hFE, 1'b1, 1'b0);
        for (int k = 0; k < 10; k++) beat(8'hFF, 1'b1, 1'b0);
        settle();
        check("R5 run broken by zero", 32'(sync_detected), 0);
        for (int k = 0; k < 6; k++) beat(8'hFF, 1'b1, 1'b0);
        settle();
        check("R5 sixteen after zero", 32'(sync_detected), 1);

        // R6: invalid cycles neither advance nor clear the run
        lreset();
        for (int k = 0; k < 8; k++) beat(8'hFF, 1'b1, 1'b0);
        for (int k = 0; k < 5; k++) beat(8'h00, 1'b0, 1'b0);
        for (int k = 0; k < 7; k++) beat(8'hFF, 1'b1, 1'b0);
        settle();
        check("R6 fifteen valid beats with gap", 32'(sync_detected), 0);
        beat(8'hFF, 1'b1, 1'b0);
        settle();
        check("R6 sixteenth valid beat", 32'(sync_detected), 1);

        // R9: sticky through zero traffic, cleared by link_reset
        for (int k = 0; k < 20; k++) beat(8'h00, 1'b1, 1'b0);
        check("R9 sticky", 32'(sync_detected), 1);
        lreset();
        check("R9 cleared by link_reset", 32'(sync_detected), 0);

        // R8: packet with a zero is abandoned
        beat(8'hFF, 1'b1, 1'b1);
        beat(8'hFF, 1'b1, 1'b0);
        beat(8'hEF, 1'b1, 1'b0);
        beat(8'hFF, 1'b1, 1'b0);
        beat(8'hFF, 1'b1, 1'b0);
        settle();
        check("R8 packet with zero", 32'(sync_detected), 0);

        // R10: flood start, hold, release
        lreset();
        tx_data_in = 8'h5A;
        @(negedge clk); tx_err_req = 1'b1;
        @(negedge clk); tx_err_req = 1'b0;
        check("R10 flood active", 32'(flood_active), 1);
        check("R10 lanes forced", 32'(tx_lanes_out), 32'hFF);
        repeat (5) @(negedge clk);
        tx_data_in = 8'h00;
        #1;
        check("R10 flood held", 32'(tx_lanes_out), 32'hFF);
        lreset();
        check("R10 released", 32'(tx_lanes_out), 32'h00);

        // R11: link_reset wins over a request in the same cycle
        @(negedge clk); tx_err_req = 1'b1; link_reset = 1'b1;
        @(negedge clk); tx_err_req = 1'b0; link_reset = 1'b0;
        check("R11 request under reset", 32'(flood_active), 0);

        // R11: link_reset on the 16th beat
        width_cfg = 2'b10;
        for (int k = 0; k < 15; k++) beat(8'hFF, 1'b1, 1'b0);
        @(negedge clk); rx_lanes = 8'hFF; rx_valid = 1'b1; link_reset = 1'b1;
        @(negedge clk); link_reset = 1'b0; rx_valid = 1'b0; rx_lanes = 8'h00;
        @(negedge clk);
        check("R11 threshold beat under reset", 32'(sync_detected), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule